// File: doc/BRIEF.md
# Serial-Loaded Channel Enable Register with Transparent Hold Latch

This block is the digital control path of a multi-channel constant-current sink driver. A controller sends a serial bit stream on a data line together with a serial clock. Each rising edge of the serial clock moves the stream one place through an N-bit shift register. The top stage of that register leaves the block on a cascade output, so several blocks can be chained and loaded from one stream. A level-sensitive hold latch copies the shift register while the latch-enable input is high. While that input is low, the latch keeps its value. Each channel enable equals its latch bit unless the blanking input is high, which turns every channel off.

The three serial inputs (serial clock, data and latch enable) are asynchronous to the block's system clock. They pass through a synchronizer of configurable depth. The block finds rising edges of the serial clock in the system clock domain. The blanking input acts combinationally on the outputs. Neither the shift register nor the latch has a power-up value. The controller writes the latch before it lowers blanking. Reset clears only the input sampling pipeline.

Top module: `sdrv_enable_reg`

## Requirements
- R1: On each detected rising edge of `sclk_i`, the sampled `sin_i` value enters shift register bit 0, and every bit k moves to bit k+1. The shift register is N_CH bits wide.
- R2: `sout_o` equals shift register bit N_CH-1. It changes only on a system clock edge that performs a shift.
- R3: While the sampled `lat_i` is high, the latch follows the shift register on every clock. A shift made during that time reaches the latch in the same clock.
- R4: While the sampled `lat_i` is low, the latch keeps its value, whatever `sclk_i` and `sin_i` do.
- R5: While `blank_i` is high, every bit of `ch_en_o` is 0. While it is low, `ch_en_o[n]` equals latch bit n. `blank_i` does not change the shift register or the latch.
- R6: `ch_en_o[n]` is driven by latch bit n. After N_CH shifts, the first bit sent is on `ch_en_o[N_CH-1]` (once latched) and on `sout_o`.
- R7: `sclk_i`, `sin_i` and `lat_i` are each sampled through SYNC_STAGES system clock flops. A rise of `sclk_i` that is present before a clock edge causes its shift on the SYNC_STAGES+1-th edge, and not before.
- R8: Synchronous active-low `rst_n` clears only the sampling pipeline. While `rst_n` is low, no shift takes place and the latch does not load. Shift register and latch contents survive reset. `sclk_i` is expected to be low when reset is released.
- R9: Two blocks chained `sout_o` to `sin_i`, with shared serial clock and latch enable, take a 2*N_CH-bit stream. The first N_CH bits sent end in the downstream block and the last N_CH bits end in the upstream block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the sampling pipeline |
| sclk_i | input | 1 | Serial shift clock, asynchronous |
| sin_i | input | 1 | Serial data in |
| lat_i | input | 1 | Latch enable, transparent while high |
| blank_i | input | 1 | Forces all channel enables off while high |
| sout_o | output | 1 | Cascade output, shift register MSB |
| ch_en_o | output | N_CH | Per-channel on/off enables |

## Verification
The bench builds the block with N_CH=16 and SYNC_STAGES=2. At these values a full word, the three-edge sampling latency and a 32-bit two-block cascade all fit in short runs, and the bench's delayed-input model can be followed exactly on every clock. Unknown power-up contents are handled with known-bit masks, so comparisons begin only after the bench has written data. Two corner cases get their own stimulus: shifting while the latch is transparent, and reset pulses that carry serial-clock and latch activity.

// File: rtl/sdrv_pkg.sv
// Package: shared defaults and bundle positions for the serial enable register.
// Assumes: the three asynchronous serial inputs travel as one bundle through the
// synchronizer, and these localparams give each input's bit within it.
package sdrv_pkg;
    localparam int DEF_CH     = 16;
    localparam int DEF_SYNC   = 2;
    localparam int IN_W       = 3;
    localparam int IDX_SCLK   = 0;
    localparam int IDX_SIN    = 1;
    localparam int IDX_LAT    = 2;
endpackage

// File: rtl/sdrv_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes: the bits are independent levels, and a skew of one cycle between bits
// is harmless because the data lines settle long before the serial clock moves.
// Reset clears every stage to 0.
module sdrv_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: move the bundle one flop deeper into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[s] <= '0;
                end else if (s == 0) begin
                    stg[s] <= d_i;
                end else begin
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sdrv_shifter.sv
// Module: serial-clock edge detector and N-bit shift register.
// Assumes: its inputs are already synchronized. The register has no reset
// because its power-up value is undefined, and only the edge detector is reset.
// Also presents the next-state value so a transparent latch can follow in the
// same clock.
module sdrv_shifter #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_s,
    input  logic         sin_s,
    output logic [N-1:0] shreg_q,
    output logic [N-1:0] shreg_d
);
    logic prev_q;
    logic rise;

    // Purpose: remember the sampled serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sclk_s;
    end

    assign rise = rst_n & sclk_s & ~prev_q;

    // Purpose: form the next register value, shifted on a detected rise.
    always_comb begin
        if (rise) shreg_d = {shreg_q[N-2:0], sin_s};
        else      shreg_d = shreg_q;
    end

    // Purpose: hold the shift register state (no reset by intent).
    always_ff @(posedge clk) begin
        shreg_q <= shreg_d;
    end

    // R1: a detected rise moves every bit up by one and takes in the data bit.
    a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (shreg_q == {$past(shreg_q[N-2:0]), $past(sin_s)}));
    // R2: without a rise the register (and so the cascade output) holds.
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(shreg_q));
    // R7: a single serial clock rise gives a single shift.
    a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sdrv_hold.sv
// Module: level-sensitive hold latch, built as an enabled register in the system
// clock domain. While enabled it loads the shift register's next value, so it
// moves on the same edge as the shifter. No reset by intent.
module sdrv_hold #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    // Purpose: follow the input while enabled, otherwise keep the value.
    always_ff @(posedge clk) begin
        if (en) q_o <= d_i;
    end

    // R4: with the latch closed, the contents do not move.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q_o));
endmodule

// File: rtl/sdrv_blank.sv
// Module: per-channel blanking gate. Purely combinational from the blanking
// input to the channel enables, so blanking never touches the stored state.
module sdrv_blank #(
    parameter int N = 16
) (
    input  logic         blank,
    input  logic [N-1:0] lat_q,
    output logic [N-1:0] en_o
);
    generate
        for (genvar c = 0; c < N; c++) begin : g_ch
            // Purpose: drive one channel enable from its latch bit unless blanked.
            assign en_o[c] = lat_q[c] & ~blank;
        end
    endgenerate
endmodule

// File: rtl/sdrv_enable_reg.sv
// Module: top of the serial-loaded channel enable register.
// Assumes: sclk_i, sin_i and lat_i are asynchronous and change slowly compared
// with clk (each level is held for at least SYNC_STAGES+2 clocks), and sclk_i is
// low when rst_n is released. Shift register and latch power up undefined.
module sdrv_enable_reg
    import sdrv_pkg::*;
#(
    parameter int N_CH        = DEF_CH,
    parameter int SYNC_STAGES = DEF_SYNC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_i,
    input  logic            sin_i,
    input  logic            lat_i,
    input  logic            blank_i,
    output logic            sout_o,
    output logic [N_CH-1:0] ch_en_o
);
    logic [IN_W-1:0] raw_in;
    logic [IN_W-1:0] syn_in;
    logic [N_CH-1:0] shreg_q;
    logic [N_CH-1:0] shreg_d;
    logic [N_CH-1:0] latch_q;
    logic            lat_en;

    // Purpose: bundle the serial inputs in package-defined positions.
    always_comb begin
        raw_in           = '0;
        raw_in[IDX_SCLK] = sclk_i;
        raw_in[IDX_SIN]  = sin_i;
        raw_in[IDX_LAT]  = lat_i;
    end

    sdrv_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    sdrv_shifter #(.N(N_CH)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (syn_in[IDX_SCLK]),
        .sin_s   (syn_in[IDX_SIN]),
        .shreg_q (shreg_q),
        .shreg_d (shreg_d)
    );

    assign lat_en = rst_n & syn_in[IDX_LAT];

    sdrv_hold #(.N(N_CH)) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (lat_en),
        .d_i   (shreg_d),
        .q_o   (latch_q)
    );

    sdrv_blank #(.N(N_CH)) blank_i_u (
        .blank (blank_i),
        .lat_q (latch_q),
        .en_o  (ch_en_o)
    );

    assign sout_o = shreg_q[N_CH-1];

    // R3: an open latch matches the shift register after every clock.
    a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
        lat_en |=> (latch_q == shreg_q));
    // R5: blanking forces every channel enable off.
    a_r5_blank: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |-> (ch_en_o == '0));
    // R2: the cascade output moves only together with the shift register.
    a_r2_sout: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(shreg_q) |-> $stable(sout_o));
endmodule

// File: tb/sdrv_enable_reg_tb_top.sv
// Bench: a behavioural model, delayed by the sampling depth, is compared on
// every clock. Targeted checks cover the corner cases and a two-block cascade.
module sdrv_enable_reg_tb_top;
    localparam int N  = 16;
    localparam int S  = 2;
    localparam int H  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sin = 1'b0, lat = 1'b0, blank = 1'b1;
    logic sout1, sout2;
    logic [N-1:0] en1, en2;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit reported = 1'b0;

    always #10 clk = ~clk;

    sdrv_enable_reg #(.N_CH(N), .SYNC_STAGES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sin_i(sin), .lat_i(lat),
        .blank_i(blank), .sout_o(sout1), .ch_en_o(en1)
    );

    sdrv_enable_reg #(.N_CH(N), .SYNC_STAGES(S)) chain_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sin_i(sout1), .lat_i(lat),
        .blank_i(blank), .sout_o(sout2), .ch_en_o(en2)
    );

    // Reference model state: values plus known-bit masks.
    logic [S-1:0] p_sclk = '0, p_sin = '0, p_lat = '0;
    logic         m_prev = 1'b0;
    logic [N-1:0] m_sh = '0, m_ksh = '0, m_lt = '0, m_klt = '0;

    // Inputs are driven 15 ns after a rising edge, so at the falling edge they
    // still hold the values that the last rising edge sampled.
    always @(negedge clk) begin
        logic [N-1:0] exp_en, msk;
        if (!rst_n) begin
            p_sclk = '0; p_sin = '0; p_lat = '0; m_prev = 1'b0;
        end else begin
            if (p_sclk[S-1] && !m_prev) begin
                m_sh  = {m_sh[N-2:0], p_sin[S-1]};
                m_ksh = {m_ksh[N-2:0], 1'b1};
            end
            if (p_lat[S-1]) begin
                m_lt  = m_sh;
                m_klt = m_ksh;
            end
            m_prev = p_sclk[S-1];
            p_sclk = {p_sclk[S-2:0], sclk};
            p_sin  = {p_sin[S-2:0], sin};
            p_lat  = {p_lat[S-2:0], lat};
        end
        total++;
        if (m_ksh[N-1] && (sout1 !== m_sh[N-1])) begin
            bad++;
            $display("FAIL R2 per-clock sout: actual=%b expected=%b", sout1, m_sh[N-1]);
        end
        exp_en = blank ? '0 : m_lt;
        msk    = blank ? '1 : m_klt;
        total++;
        if (((en1 ^ exp_en) & msk) !== '0) begin
            bad++;
            $display("FAIL R5 per-clock ch_en: actual=%h expected=%h mask=%h", en1, exp_en, msk);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #15;
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        sin = b; sclk = 1'b0;
        tick(H);
        sclk = 1'b1;
        tick(H);
        sclk = 1'b0;
    endtask

    task automatic send_word(logic [N-1:0] w);
        for (int i = N-1; i >= 0; i--) send_bit(w[i]);
        tick(H);
    endtask

    task automatic pulse_lat();
        lat = 1'b1; tick(H);
        lat = 1'b0; tick(H);
    endtask

    initial begin
        logic [N-1:0] w;
        tick(5);
        chk("R5 reset blanked ch_en", 32'(en1), 32'h0);
        rst_n = 1'b1;
        tick(H);

        // R6 and R3: load a word, open the latch, unblank.
        send_word(16'hA5C3);
        chk("R6 sout carries first bit after 16 shifts", 32'(sout1), 32'h1);
        pulse_lat();
        blank = 1'b0; tick(1);
        chk("R3 latched word on ch_en", 32'(en1), 32'h0000A5C3);
        chk("R6 first bit on top channel", 32'(en1[N-1]), 32'h1);

        // R4 then R1: shift four bits with the latch closed, then open it.
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        tick(H);
        chk("R4 closed latch unchanged after shifts", 32'(en1), 32'h0000A5C3);
        pulse_lat();
        w = 16'h5C3B;
        chk("R1 shift direction and entry bit", 32'(en1), 32'(w));

        // R3: transparent latch follows shifts directly.
        lat = 1'b1; tick(H);
        send_bit(1'b0); tick(H);
        chk("R3 shift during open latch reaches outputs", 32'(en1), 32'hB876);
        lat = 1'b0; tick(H);

        // R5: blanking gates outputs and leaves contents alone.
        blank = 1'b1; tick(1);
        chk("R5 blank high forces all off", 32'(en1), 32'h0);
        send_bit(1'b1); tick(H);
        blank = 1'b0; tick(1);
        chk("R5 latch intact after blank", 32'(en1), 32'hB876);
        pulse_lat();
        chk("R5 shift register intact after blank", 32'(en1), 32'h70ED);

        // R8: reset with serial activity keeps data and does nothing.
        rst_n = 1'b0; tick(2);
        lat = 1'b1; sin = 1'b0; sclk = 1'b1; tick(H);
        sclk = 1'b0; lat = 1'b0; tick(H);
        rst_n = 1'b1; tick(H);
        chk("R8 latch kept through reset", 32'(en1), 32'h70ED);
        pulse_lat();
        chk("R8 no shift during reset", 32'(en1), 32'h70ED);

        // R7: latency from a serial clock rise to the shift.
        send_word(16'h4000);
        chk("R7 setup sout low", 32'(sout1), 32'h0);
        sin = 1'b0; sclk = 1'b1;
        tick(S);
        chk("R7 no shift before S+1 edges", 32'(sout1), 32'h0);
        tick(1);
        chk("R7 shift on edge S+1", 32'(sout1), 32'h1);
        sclk = 1'b0; tick(H);

        // R9: 32-bit stream through two chained blocks.
        send_word(16'h1E2D);
        send_word(16'hC7F0);
        pulse_lat();
        chk("R9 downstream gets first word", 32'(en2), 32'h1E2D);
        chk("R9 upstream gets last word", 32'(en1), 32'hC7F0);

        done = 1'b1;
        if (!reported) begin
            reported = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done && !reported) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            reported = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule